// File: doc/BRIEF.md
# Adjacent Match Points Calculator

This block scores a single play in a game that shows a row of four digit positions. For every position it receives one match line, high when that position's digit equals the digit just played. It also receives the index of the position that was played and a flag that is high when the played digit is zero. From these it finds the unbroken run of matching neighbours around the played position and gives the run length as a small binary number. A zero digit never earns a run.

The same block keeps one points register for each of the two players. It adds an externally supplied reward value to the current player's points and shows the wrapped sum and the carry out straight away. On a play strobe it writes the sum back into that player's register and captures the carry in a flag register. Control logic reads that flag in the next clock period to end the game.

Top module: `play_score_unit`

## Requirements
- R1: When pos_i is 3, run_len_o counts the consecutive set bits of match_i that start at bit 2 and go down towards bit 0. Bit k of match_i belongs to position k.
- R2: When pos_i is 0, run_len_o counts the consecutive set bits of match_i that start at bit 1 and go up towards bit 3.
- R3: When pos_i is 1 or 2, run_len_o is the upward run from the next higher bit plus the downward run from the next lower bit. The total is capped at RUN_MAX (3).
- R4: A pos_i value of p selects position p. With match_i = 4'b0100, pos_i values 3, 2, 1 and 0 give 1, 0, 1 and 0.
- R5: When zero_dig_i is 1, run_len_o is 0 whatever match_i and pos_i are.
- R6: new_pts_o equals (current points + reward_i) mod 256. The current points are pts0_o when player_i is 0 and pts1_o when player_i is 1.
- R7: carry_o is 1 exactly when current points + reward_i is greater than 255.
- R8: At a rising clk edge with play_i = 1, the selected player's register takes new_pts_o and the other register keeps its value. Without play_i, neither register changes.
- R9: ovf_q_o takes the value of carry_o at every rising edge with play_i = 1 and holds it at every other edge.
- R10: At a rising edge with rst = 1, pts0_o, pts1_o and ovf_q_o become 0. This happens regardless of play_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| match_i | input | 4 | Per-position match lines, bit k is position k |
| pos_i | input | 2 | Index of the played position |
| zero_dig_i | input | 1 | High when the played digit is zero |
| reward_i | input | 8 | Reward points for this play |
| player_i | input | 1 | Current player, 0 or 1 |
| play_i | input | 1 | Commit strobe for the new points and the overflow |
| run_len_o | output | 2 | Binary length of the adjacent run |
| new_pts_o | output | 8 | Wrapped sum of current points and reward |
| carry_o | output | 1 | Sum exceeded 8 bits |
| ovf_q_o | output | 1 | Registered overflow flag |
| pts0_o | output | 8 | Player 0 points register |
| pts1_o | output | 8 | Player 1 points register |

## Verification
The run path is combinational. A wrong run computed for one position therefore shows up on run_len_o in the same cycle, but only while pos_i selects that position. For this reason every match pattern is applied at every position, both with and without the zero flag. A fault in the points registers or in the overflow flag appears one edge after the play strobe that caused it. It then persists, because the sum that follows is built on the corrupted register. The bench therefore checks the registers after each strobe, and again after edges that have no strobe.

// File: rtl/score_pkg.sv
package score_pkg;

   // Limit a raw neighbour count to the longest run the encoder can report.
   function automatic int unsigned cap_run(input int unsigned total, input int unsigned limit);
      return (total > limit) ? limit : total;
   endfunction

endpackage

// File: rtl/adj_run_unit.sv
module adj_run_unit
   import score_pkg::*;
#(
   parameter int unsigned POS_CNT = 4,
   parameter int unsigned RUN_MAX = 3
) (
   input  logic [POS_CNT-1:0]         match_i,
   output logic [POS_CNT*RUN_MAX-1:0] therm_o
);

   for (genvar p = 0; p < POS_CNT; p++) begin : g_pos
      int unsigned up_n;
      int unsigned dn_n;
      int unsigned tot_n;
      logic        go_up;
      logic        go_dn;
      logic [RUN_MAX-1:0] therm_p;

      always_comb begin
         up_n  = 0;
         go_up = 1'b1;
         for (int k = p + 1; k < int'(POS_CNT); k++) begin
            if (go_up && match_i[k]) up_n = up_n + 1;
            else                     go_up = 1'b0;
         end
         dn_n  = 0;
         go_dn = 1'b1;
         for (int k = p - 1; k >= 0; k--) begin
            if (go_dn && match_i[k]) dn_n = dn_n + 1;
            else                     go_dn = 1'b0;
         end
         tot_n = cap_run(up_n + dn_n, RUN_MAX);
         for (int i = 0; i < int'(RUN_MAX); i++) begin
            therm_p[RUN_MAX-1-i] = (tot_n > i);
         end
      end

      assign therm_o[p*RUN_MAX +: RUN_MAX] = therm_p;
   end

endmodule

// File: rtl/adj_select_encode.sv
module adj_select_encode #(
   parameter int unsigned POS_CNT   = 4,
   parameter int unsigned RUN_MAX   = 3,
   parameter bit          ENC_COUNT = 1'b1,
   localparam int unsigned PSW      = $clog2(POS_CNT),
   localparam int unsigned CW       = $clog2(RUN_MAX + 1)
) (
   input  logic [POS_CNT*RUN_MAX-1:0] therm_i,
   input  logic [PSW-1:0]             pos_i,
   input  logic                       zero_i,
   output logic [CW-1:0]              count_o
);

   logic [RUN_MAX-1:0] sel;
   int unsigned        base;

   always_comb begin
      base = int'(pos_i) * RUN_MAX;
      sel  = zero_i ? '0 : therm_i[base +: RUN_MAX];
   end

   if (ENC_COUNT) begin : g_count
      always_comb begin
         count_o = '0;
         for (int i = 0; i < int'(RUN_MAX); i++) begin
            count_o = count_o + CW'(sel[i]);
         end
      end
   end else begin : g_prio
      always_comb begin
         count_o = '0;
         for (int i = 0; i < int'(RUN_MAX); i++) begin
            if (sel[RUN_MAX-1-i]) count_o = CW'(i + 1);
         end
      end
   end

endmodule

// File: rtl/pts_adder.sv
module pts_adder #(
   parameter int unsigned PTW = 8
) (
   input  logic [PTW-1:0] a_i,
   input  logic [PTW-1:0] b_i,
   output logic [PTW-1:0] sum_o,
   output logic           carry_o
);

   assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};

endmodule

// File: rtl/play_score_unit.sv
module play_score_unit #(
   parameter int unsigned POS_CNT   = 4,
   parameter int unsigned RUN_MAX   = 3,
   parameter int unsigned PTW       = 8,
   parameter bit          ENC_COUNT = 1'b1,
   localparam int unsigned PSW      = $clog2(POS_CNT),
   localparam int unsigned CW       = $clog2(RUN_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [POS_CNT-1:0] match_i,
   input  logic [PSW-1:0]     pos_i,
   input  logic               zero_dig_i,
   input  logic [PTW-1:0]     reward_i,
   input  logic               player_i,
   input  logic               play_i,
   output logic [CW-1:0]      run_len_o,
   output logic [PTW-1:0]     new_pts_o,
   output logic               carry_o,
   output logic               ovf_q_o,
   output logic [PTW-1:0]     pts0_o,
   output logic [PTW-1:0]     pts1_o
);

   if (POS_CNT < 2 || (1 << PSW) != POS_CNT) begin : g_bad_pos
      $error("POS_CNT must be a power of two of at least 2");
   end
   if (RUN_MAX < 1 || RUN_MAX > POS_CNT - 1) begin : g_bad_run
      $error("RUN_MAX must lie between 1 and POS_CNT-1");
   end
   if (PTW < 2) begin : g_bad_ptw
      $error("PTW must be at least 2");
   end

   logic [POS_CNT*RUN_MAX-1:0] therm_all;
   logic [PTW-1:0]             cur_pts;
   logic [PTW-1:0]             pts_q [2];
   logic                       ovf_q;

   adj_run_unit #(.POS_CNT(POS_CNT), .RUN_MAX(RUN_MAX)) i_run (
      .match_i (match_i),
      .therm_o (therm_all)
   );

   adj_select_encode #(.POS_CNT(POS_CNT), .RUN_MAX(RUN_MAX), .ENC_COUNT(ENC_COUNT)) i_enc (
      .therm_i (therm_all),
      .pos_i   (pos_i),
      .zero_i  (zero_dig_i),
      .count_o (run_len_o)
   );

   assign cur_pts = pts_q[player_i];

   pts_adder #(.PTW(PTW)) i_add (
      .a_i     (cur_pts),
      .b_i     (reward_i),
      .sum_o   (new_pts_o),
      .carry_o (carry_o)
   );

   for (genvar g = 0; g < 2; g++) begin : g_plr
      always_ff @(posedge clk) begin
         if (rst)                                  pts_q[g] <= '0;
         else if (play_i && (player_i == 1'(g)))   pts_q[g] <= new_pts_o;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         ovf_q <= 1'b0;
      else if (play_i) ovf_q <= carry_o;
   end

   assign ovf_q_o = ovf_q;
   assign pts0_o  = pts_q[0];
   assign pts1_o  = pts_q[1];

endmodule

// File: rtl/play_score_chk.sv
module play_score_chk #(
   parameter int unsigned POS_CNT = 4,
   parameter int unsigned PSW     = 2,
   parameter int unsigned CW      = 2,
   parameter int unsigned PTW     = 8
) (
   input logic               clk,
   input logic               rst,
   input logic [POS_CNT-1:0] match_i,
   input logic [PSW-1:0]     pos_i,
   input logic               zero_dig_i,
   input logic [PTW-1:0]     reward_i,
   input logic               player_i,
   input logic               play_i,
   input logic [CW-1:0]      run_len_o,
   input logic [PTW-1:0]     new_pts_o,
   input logic               carry_o,
   input logic               ovf_q_o,
   input logic [PTW-1:0]     pts0_o,
   input logic [PTW-1:0]     pts1_o
);

   // R5
   zero_digit_chk: assert property (@(posedge clk) disable iff (rst)
      zero_dig_i |-> run_len_o == '0);

   // R1
   no_match_chk: assert property (@(posedge clk) disable iff (rst)
      match_i == '0 |-> run_len_o == '0);

   // R7
   wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
      carry_o == (new_pts_o < reward_i));

   // R8
   load_p0_chk: assert property (@(posedge clk) disable iff (rst)
      play_i && !player_i |=> pts0_o == $past(new_pts_o) && pts1_o == $past(pts1_o));

   // R8
   load_p1_chk: assert property (@(posedge clk) disable iff (rst)
      play_i && player_i |=> pts1_o == $past(new_pts_o) && pts0_o == $past(pts0_o));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !play_i |=> $stable(pts0_o) && $stable(pts1_o));

   // R9
   ovf_capture_chk: assert property (@(posedge clk) disable iff (rst)
      play_i |=> ovf_q_o == $past(carry_o));

   // R9
   ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !play_i |=> $stable(ovf_q_o));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> pts0_o == '0 && pts1_o == '0 && !ovf_q_o);

endmodule

bind play_score_unit play_score_chk #(
   .POS_CNT(POS_CNT), .PSW(PSW), .CW(CW), .PTW(PTW)
) i_chk (
   .clk(clk), .rst(rst), .match_i(match_i), .pos_i(pos_i),
   .zero_dig_i(zero_dig_i), .reward_i(reward_i), .player_i(player_i),
   .play_i(play_i), .run_len_o(run_len_o), .new_pts_o(new_pts_o),
   .carry_o(carry_o), .ovf_q_o(ovf_q_o), .pts0_o(pts0_o), .pts1_o(pts1_o)
);

// File: tb/test_play_score_unit.sv
module test_play_score_unit;

   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] match_i = '0;
   logic [1:0] pos_i = '0;
   logic       zero_dig_i = 1'b0;
   logic [7:0] reward_i = '0;
   logic       player_i = 1'b0;
   logic       play_i = 1'b0;
   logic [1:0] run_len_o;
   logic [7:0] new_pts_o;
   logic       carry_o;
   logic       ovf_q_o;
   logic [7:0] pts0_o;
   logic [7:0] pts1_o;

   int total = 0;
   int bad   = 0;

   play_score_unit i_play_score_unit (
      .clk(clk), .rst(rst), .match_i(match_i), .pos_i(pos_i),
      .zero_dig_i(zero_dig_i), .reward_i(reward_i), .player_i(player_i),
      .play_i(play_i), .run_len_o(run_len_o), .new_pts_o(new_pts_o),
      .carry_o(carry_o), .ovf_q_o(ovf_q_o), .pts0_o(pts0_o), .pts1_o(pts1_o)
   );

   always #(CLK_PER/2) clk = ~clk;

   typedef struct packed {
      logic [3:0] m;
      logic [1:0] p;
      logic       z;
      logic [1:0] exp;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{4'b0100, 2'd3, 1'b0, 2'd1},
      '{4'b0100, 2'd2, 1'b0, 2'd0},
      '{4'b0100, 2'd1, 1'b0, 2'd1},
      '{4'b0100, 2'd0, 1'b0, 2'd0},
      '{4'b1111, 2'd1, 1'b0, 2'd3},
      '{4'b1111, 2'd2, 1'b1, 2'd0},
      '{4'b0111, 2'd3, 1'b0, 2'd3},
      '{4'b1110, 2'd0, 1'b0, 2'd3},
      '{4'b0101, 2'd1, 1'b0, 2'd2},
      '{4'b1011, 2'd2, 1'b0, 2'd3}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int ref_run(input logic [3:0] m, input int p, input logic z);
      int n;
      if (z) return 0;
      n = 0;
      for (int k = p + 1; k < 4; k++) begin
         if (!m[k]) break;
         n++;
      end
      for (int k = p - 1; k >= 0; k--) begin
         if (!m[k]) break;
         n++;
      end
      return (n > 3) ? 3 : n;
   endfunction

   task automatic play_step(input logic plr, input logic [7:0] rwd, input logic go);
      @(negedge clk);
      player_i = plr;
      reward_i = rwd;
      play_i   = go;
      #1;
   endtask

   initial begin
      #(CLK_PER * 100000);
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R10 reset state
      chk("R10 pts0", pts0_o, 0);
      chk("R10 pts1", pts1_o, 0);
      chk("R10 ovf", ovf_q_o, 0);
      rst = 1'b0;

      // R4 example and directed table
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         match_i = VECS[i].m; pos_i = VECS[i].p; zero_dig_i = VECS[i].z;
         #1;
         chk("R4 table", run_len_o, VECS[i].exp);
      end

      // R1 R2 R3 R5 full sweep
      for (int z = 0; z < 2; z++) begin
         for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
               @(negedge clk);
               match_i = 4'(m); pos_i = 2'(p); zero_dig_i = 1'(z);
               #1;
               chk(z == 1 ? "R5 sweep" : p == 3 ? "R1 sweep" : p == 0 ? "R2 sweep" : "R3 sweep",
                   run_len_o, ref_run(4'(m), p, 1'(z)));
            end
         end
      end
      zero_dig_i = 1'b0;

      // points path
      play_step(1'b0, 8'd100, 1'b1);
      chk("R6 sum p0", new_pts_o, 100);
      chk("R7 no carry", carry_o, 0);
      play_step(1'b1, 8'd200, 1'b1);
      chk("R8 load p0", pts0_o, 100);
      chk("R8 p1 kept", pts1_o, 0);
      chk("R6 sum p1", new_pts_o, 200);
      play_step(1'b1, 8'd60, 1'b1);
      chk("R8 load p1", pts1_o, 200);
      chk("R6 wrap", new_pts_o, 4);
      chk("R7 carry", carry_o, 1);
      play_step(1'b0, 8'd200, 1'b0);
      chk("R8 wrap load", pts1_o, 4);
      chk("R9 capture", ovf_q_o, 1);
      chk("R6 idle sum", new_pts_o, 44);
      chk("R7 idle carry", carry_o, 1);
      play_step(1'b0, 8'd155, 1'b1);
      chk("R8 idle p0", pts0_o, 100);
      chk("R8 idle p1", pts1_o, 4);
      chk("R9 hold", ovf_q_o, 1);
      chk("R7 edge 255", carry_o, 0);
      chk("R6 edge 255", new_pts_o, 255);
      play_step(1'b0, 8'd1, 1'b0);
      chk("R8 load 255", pts0_o, 255);
      chk("R9 recapture", ovf_q_o, 0);
      chk("R7 edge 256", carry_o, 1);
      chk("R6 edge 256", new_pts_o, 0);

      // R10 reset wins over play
      @(negedge clk);
      rst = 1'b1; play_i = 1'b1; player_i = 1'b1; reward_i = 8'd10;
      @(negedge clk);
      chk("R10 pts0 clr", pts0_o, 0);
      chk("R10 pts1 clr", pts1_o, 0);
      chk("R10 ovf clr", ovf_q_o, 0);
      rst = 1'b0; play_i = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule